// File: doc/BRIEF.md
# Rollover Flag and Interrupt Router

This unit gathers status for a real-time clock and steers its interrupts. Six rollover pulses, one per time unit, each set their own sticky flag. Software reads all six flags at once through a register port, and that read clears them. A seventh bit has two roles. When read, it reports that the oscillator has failed. When written, it selects the supply mode, and the chosen mode leaves the block on the `single_supply` pin. An eighth bit opens a scratch test register at address 0x1F.

A routing register steers each of five interrupt sources. A source goes either to the multi-function output or to the main interrupt output. A source counts only while it is both pending and enabled. The register port is plain control: a read or write strobe with an address, and read data that is valid in the same cycle. There is no back-pressure, so every access completes in one cycle.

Top module: `rtc_flag_router`

## Requirements
- R1: A one-cycle pulse on `rollover_evt[i]` sets bit i of the flag register (address 0x03). The bit stays set until the register is read.
- R2: A read of address 0x03 returns the flags as they were before the read. Bits 5:0 are zero from the next cycle on.
- R3: An event that arrives in the same cycle as the clearing read is not lost. Its bit reads 1 on the next read.
- R4: Bit 6 of a read of 0x03 is 1 after reset and after any cycle with `osc_fail` high.
- R5: A `clk_start_wr` pulse while `osc_running` is 1 clears the read view of bit 6. The same pulse while `osc_running` is 0 leaves the bit at 1.
- R6: `single_supply` follows the last value written to bit 6 of 0x03. It is forced to 1 by reset and by `osc_fail`.
- R7: Bit 7 of 0x03 is read/write and resets to 0. While it is 1, the test register at 0x1F stores writes and reads them back.
- R8: While bit 7 is 0, the test register reads as 0 and ignores writes.
- R9: The routing register at 0x04 resets to 0. Bits 4:0 are read/write. Bits 7:5 read as 0.
- R10: `irq_mfo` is the OR of sources that are pending, enabled and have their routing bit at 1. `irq_main` is the OR of sources that are pending, enabled and have their routing bit at 0.
- R11: Writes to bits 5:0 of 0x03 have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of 0x03 clears the flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the same cycle as the address |
| rollover_evt | input | 6 | Rollover event pulses |
| osc_fail | input | 1 | Oscillator failure detected |
| osc_running | input | 1 | The oscillator is running |
| clk_start_wr | input | 1 | Pulse: 1 written to the clock start bit |
| irq_pend | input | 5 | Pending interrupt sources |
| irq_en | input | 5 | Enabled interrupt sources |
| irq_main | output | 1 | Main interrupt output |
| irq_mfo | output | 1 | Multi-function output |
| single_supply | output | 1 | Supply mode: 1 means single supply, 0 means battery backed |

## Verification
The assertions assume two things about the inputs. First, `rollover_evt` and `osc_fail` are synchronous pulses that are low during reset. Second, `reg_rd` and `reg_wr` are never high in the same cycle. The bench drives every input on the falling clock edge and never asserts both strobes together. It also returns event and failure pulses to 0 after one cycle. This means each post-edge property only ever sees inputs that were clean when they were sampled.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  localparam logic [4:0] FLAG_ADDR  = 5'h03;
  localparam logic [4:0] ROUTE_ADDR = 5'h04;
  localparam logic [4:0] TEST_ADDR  = 5'h1F;

  typedef enum logic [1:0] {
    SEL_FLAG,
    SEL_ROUTE,
    SEL_TEST,
    SEL_NONE
  } rsel_e;
endpackage

// File: rtl/rfr_flags.sv
module rfr_flags #(
  parameter int N_EVT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] evt,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic [1:0]       wcfg,
  input  logic             osc_fail,
  input  logic             osc_running,
  input  logic             clk_start_wr,
  output logic [N_EVT-1:0] flags_q,
  output logic             osc_flag_q,
  output logic             single_supply,
  output logic             test_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q       <= '0;
      osc_flag_q    <= 1'b1;
      single_supply <= 1'b1;
      test_en       <= 1'b0;
    end else begin
      // an event in the clearing cycle survives
      flags_q <= (rd_hit ? '0 : flags_q) | evt;
      if (osc_fail)
        osc_flag_q <= 1'b1;
      else if (clk_start_wr && osc_running)
        osc_flag_q <= 1'b0;
      if (osc_fail)
        single_supply <= 1'b1;
      else if (wr_hit)
        single_supply <= wcfg[0];
      if (wr_hit)
        test_en <= wcfg[1];
    end
  end

  // R1
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));
  // R2
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> ((flags_q & ~$past(evt)) == '0));
  // R11
  wr_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !rd_hit && evt == '0) |=> $stable(flags_q));
  // R4
  osc_fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> osc_flag_q);
  // R5
  osc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_start_wr && osc_running && !osc_fail) |=> !osc_flag_q);
  // R6
  supply_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> single_supply);
endmodule

// File: rtl/rfr_testreg.sv
module rfr_testreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_en,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_view
);
  logic [DW-1:0] test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 test_q <= '0;
    else if (wr_hit && test_en) test_q <= wdata;
  end

  assign rd_view = test_en ? test_q : '0;

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en) |=> $stable(test_q));
endmodule

// File: rtl/rfr_router.sv
module rfr_router #(
  parameter int N_IRQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [N_IRQ-1:0] wdata,
  input  logic [N_IRQ-1:0] pend,
  input  logic [N_IRQ-1:0] en,
  output logic [N_IRQ-1:0] route_q,
  output logic             irq_main,
  output logic             irq_mfo
);
  logic [N_IRQ-1:0] to_mfo, to_main;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      route_q <= '0;
    else if (wr_hit) route_q <= wdata;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_steer
    logic live;
    assign live       = pend[i] & en[i];
    assign to_mfo[i]  = live & route_q[i];
    assign to_main[i] = live & ~route_q[i];
  end

  assign irq_mfo  = |to_mfo;
  assign irq_main = |to_main;

  // R10
  all_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '0) |-> !irq_mfo);
  // R10
  all_mfo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q == '1) |-> !irq_main);
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & en) == '0) |-> (!irq_main && !irq_mfo));
endmodule

// File: rtl/rtc_flag_router.sv
module rtc_flag_router
  import rfr_pkg::*;
#(
  parameter int N_EVT = 6,
  parameter int N_IRQ = 5,
  parameter int AW    = 5,
  localparam int DW   = N_EVT + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_EVT-1:0] rollover_evt,
  input  logic             osc_fail,
  input  logic             osc_running,
  input  logic             clk_start_wr,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  output logic             irq_main,
  output logic             irq_mfo,
  output logic             single_supply
);
  rsel_e            sel;
  logic [N_EVT-1:0] flags_q;
  logic             osc_flag_q, test_en;
  logic [N_IRQ-1:0] route_q;
  logic [DW-1:0]    test_view;

  always_comb begin
    if (reg_addr == AW'(FLAG_ADDR))       sel = SEL_FLAG;
    else if (reg_addr == AW'(ROUTE_ADDR)) sel = SEL_ROUTE;
    else if (reg_addr == AW'(TEST_ADDR))  sel = SEL_TEST;
    else                                  sel = SEL_NONE;
  end

  rfr_flags #(.N_EVT(N_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(rollover_evt),
    .rd_hit(reg_rd && sel == SEL_FLAG),
    .wr_hit(reg_wr && sel == SEL_FLAG),
    .wcfg(reg_wdata[DW-1:N_EVT]),
    .osc_fail(osc_fail), .osc_running(osc_running),
    .clk_start_wr(clk_start_wr), .flags_q(flags_q),
    .osc_flag_q(osc_flag_q), .single_supply(single_supply),
    .test_en(test_en)
  );

  rfr_testreg #(.DW(DW)) u_test (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .wr_hit(reg_wr && sel == SEL_TEST),
    .wdata(reg_wdata), .rd_view(test_view)
  );

  rfr_router #(.N_IRQ(N_IRQ)) u_route (
    .clk(clk), .rst_n(rst_n),
    .wr_hit(reg_wr && sel == SEL_ROUTE),
    .wdata(reg_wdata[N_IRQ-1:0]),
    .pend(irq_pend), .en(irq_en), .route_q(route_q),
    .irq_main(irq_main), .irq_mfo(irq_mfo)
  );

  always_comb begin
    unique case (sel)
      SEL_FLAG:  reg_rdata = {test_en, osc_flag_q, flags_q};
      SEL_ROUTE: reg_rdata = {{(DW-N_IRQ){1'b0}}, route_q};
      SEL_TEST:  reg_rdata = test_view;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/tb_rtc_flag_router.sv
module tb_rtc_flag_router;
  logic clk = 0, rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [5:0] rollover_evt = 0;
  logic osc_fail = 0, osc_running = 0, clk_start_wr = 0;
  logic [4:0] irq_pend = 0, irq_en = 0;
  logic irq_main, irq_mfo, single_supply;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  rtc_flag_router dut (.*);

  // {pend, en, route, exp_main, exp_mfo}
  localparam logic [16:0] VEC [8] = '{
    {5'b11111, 5'b11111, 5'b00000, 1'b1, 1'b0},
    {5'b11111, 5'b11111, 5'b11111, 1'b0, 1'b1},
    {5'b00001, 5'b00001, 5'b00010, 1'b1, 1'b0},
    {5'b00010, 5'b00010, 5'b00010, 1'b0, 1'b1},
    {5'b10000, 5'b00000, 5'b10000, 1'b0, 1'b0},
    {5'b10100, 5'b10100, 5'b00100, 1'b1, 1'b1},
    {5'b00000, 5'b11111, 5'b11111, 1'b0, 1'b0},
    {5'b01000, 5'b01000, 5'b10111, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #2 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic pulse_evt(input logic [5:0] e);
    @(negedge clk); rollover_evt = e;
    @(negedge clk); rollover_evt = 0;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(5'h03, d); chk("R4 reset osc flag", d, 8'h40);
    chk("R6 reset supply", {7'd0, single_supply}, 8'h01);
    rd(5'h04, d); chk("R9 reset route", d, 8'h00);
    rd(5'h1F, d); chk("R8 test locked", d, 8'h00);
    // R5 oscillator restart
    @(negedge clk); clk_start_wr = 1; osc_running = 0;
    @(negedge clk); clk_start_wr = 0;
    rd(5'h03, d); chk("R5 not running keeps flag", d, 8'h40);
    osc_running = 1;
    @(negedge clk); clk_start_wr = 1;
    @(negedge clk); clk_start_wr = 0;
    rd(5'h03, d); chk("R5 running clears flag", d, 8'h00);
    // R6 / R11
    wr(5'h03, 8'h00); chk("R6 battery mode", {7'd0, single_supply}, 8'h00);
    wr(5'h03, 8'h3F); rd(5'h03, d); chk("R11 write no flag effect", d, 8'h00);
    chk("R6 supply holds", {7'd0, single_supply}, 8'h00);
    // R1 / R2
    pulse_evt(6'b101001);
    rd(5'h03, d); chk("R1 flags set", d, 8'h29);
    rd(5'h03, d); chk("R2 read cleared", d, 8'h00);
    pulse_evt(6'b000010); pulse_evt(6'b010000);
    rd(5'h03, d); chk("R1 sticky accumulate", d, 8'h12);
    // R3 coincident event and read
    pulse_evt(6'b100000);
    @(negedge clk); reg_addr = 5'h03; reg_rd = 1; rollover_evt = 6'b000100;
    #2 d = reg_rdata; chk("R2 pre-clear value", d, 8'h20);
    @(negedge clk); reg_rd = 0; rollover_evt = 0;
    rd(5'h03, d); chk("R3 coincident event kept", d, 8'h04);
    rd(5'h03, d); chk("R2 cleared after", d, 8'h00);
    // R7 / R8 test register
    wr(5'h1F, 8'hA5);
    wr(5'h03, 8'h80);
    rd(5'h1F, d); chk("R8 locked write ignored", d, 8'h00);
    rd(5'h03, d); chk("R7 enable bit reads", d, 8'h80);
    wr(5'h1F, 8'h5A);
    rd(5'h1F, d); chk("R7 test reg rw", d, 8'h5A);
    wr(5'h03, 8'h00);
    rd(5'h1F, d); chk("R8 reads zero when locked", d, 8'h00);
    // R9
    wr(5'h04, 8'hFF); rd(5'h04, d); chk("R9 route width", d, 8'h1F);
    // R10 vector table
    for (int i = 0; i < 8; i++) begin
      wr(5'h04, {3'b0, VEC[i][6:2]});
      @(negedge clk); irq_pend = VEC[i][16:12]; irq_en = VEC[i][11:7];
      #2 chk("R10 steering", {6'd0, irq_main, irq_mfo}, {6'd0, VEC[i][1:0]});
    end
    // R4 / R6 oscillator failure
    @(negedge clk); osc_fail = 1;
    @(negedge clk); osc_fail = 0;
    rd(5'h03, d); chk("R4 fail sets flag", d, 8'h40);
    chk("R6 fail forces single", {7'd0, single_supply}, 8'h01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule